// File: doc/BRIEF.md
# Dual-Output Interrupt Controller

This block collects 32 interrupt request lines that are not synchronous to its clock and turns them into two combined requests for a processor: a normal request (`irq_o`) and a fast request (`fiq_o`). Each line is first brought into the clock domain. Software then chooses, line by line, whether the line counts as a level or as an edge, and which polarity is active.

Edge events are held in a pending latch until software clears them. Software clears a latch by writing a one to the matching bit of the raw register. A level line shows its current state in the raw register. An enable mask decides which raw bits reach the status register. A routing register then sends each enabled bit to either the normal output or the fast output.

Software reaches six 32-bit registers through a word-addressed bus with separate read and write strobes. Register reads are combinational.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: Register word indices on `addr_i` are: 0 enable mask, 1 raw pending, 2 masked status (read only), 3 polarity, 4 trigger type, 5 fast-route select. Bit n of every register belongs to source n. `rdata_o` shows the addressed register while `rd_i` is high. Indices 6 and 7 read as zero.
- R2: After reset, the mask, polarity, type, route and edge latches are all zero, and both outputs are low.
- R3: Each source passes through two flops before it is used. A level source's raw bit changes on the second rising clock edge after its input changes.
- R4: For a level source (type bit 0), the raw bit is 1 when the input equals its polarity bit: 1 means active high and 0 means active low.
- R5: For an edge source (type bit 1), polarity 1 latches a rising edge and polarity 0 latches a falling edge. The raw bit sets on the third clock edge after the input change. It stays set after the input returns, and an input change of the opposite direction does not set it.
- R6: A write to the raw register with bit n at 1 clears source n's edge latch. A bit written as 0 leaves its latch unchanged.
- R7: Writing 1 to the raw bit of a level source whose input is still active leaves the raw bit at 1.
- R8: If a new edge event and an acknowledge for the same bit fall on the same clock edge, the bit stays pending.
- R9: Status equals raw AND mask. A source whose mask bit is 0 reaches neither output.
- R10: `irq_o` is the OR of status bits whose route bit is 0. `fiq_o` is the OR of status bits whose route bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt request lines, not synchronous to the clock |
| addr_i | input | 3 | Register word index |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, zero while `rd_i` is low |
| irq_o | output | 1 | Combined normal request |
| fiq_o | output | 1 | Combined fast request |

## Verification
Level behaviour is tried through a table of input words and polarity words. Some combinations match every bit, some match none, and some match only half. This separates a missing polarity inversion from a swapped one. The same table varies the mask and the route words, so that a leak through a masked bit and a request routed to the wrong output each show up on their own.

Directed edge sequences then drive rises and falls against both polarities. They check the exact edge on which a latch sets, and they check that a latch holds after the input returns. They also check that writing 0 to a raw bit, and acknowledging a level source, leave the bit set. One sequence lines an acknowledge up with a fresh edge on the same clock edge, so that the two possible outcomes can be told apart.

// File: rtl/irq_fiq_ctrl_pkg.sv
package irq_fiq_ctrl_pkg;
  localparam int unsigned NSRC = 32;
  localparam int unsigned AW   = 3;

  typedef enum logic [AW-1:0] {
    A_MASK = 3'd0,
    A_RAW  = 3'd1,
    A_STAT = 3'd2,
    A_POL  = 3'd3,
    A_TYPE = 3'd4,
    A_FIQ  = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/irq_fiq_sync.sv
module irq_fiq_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_fiq_detect.sv
module irq_fiq_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] type_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] latch_o,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_src
    logic act_now, act_prev;
    assign act_now  = ~(sync_i[g] ^ pol_i[g]);
    assign act_prev = ~(prev_q[g] ^ pol_i[g]);
    assign evt_o[g] = act_now & ~act_prev;

    // new edge beats a simultaneous acknowledge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        latch_q[g] <= 1'b0;
      else if (!type_i[g]) latch_q[g] <= 1'b0;
      else                latch_q[g] <= evt_o[g] | (latch_q[g] & ~ack_i[g]);
    end

    assign raw_o[g] = type_i[g] ? latch_q[g] : act_now;
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/irq_fiq_regs.sv
module irq_fiq_regs
  import irq_fiq_ctrl_pkg::*;
#(
  parameter int unsigned W = NSRC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          rd_i,
  output logic [W-1:0]  rdata_o,
  input  logic [W-1:0]  raw_i,
  input  logic [W-1:0]  status_i,
  output logic [W-1:0]  mask_o,
  output logic [W-1:0]  pol_o,
  output logic [W-1:0]  type_o,
  output logic [W-1:0]  fiq_o,
  output logic [W-1:0]  ack_o
);
  logic [W-1:0] mask_q, pol_q, type_q, fiq_q;
  logic [W-1:0] rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      pol_q  <= '0;
      type_q <= '0;
      fiq_q  <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_MASK:  mask_q <= wdata_i;
        A_POL:   pol_q  <= wdata_i;
        A_TYPE:  type_q <= wdata_i;
        A_FIQ:   fiq_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign ack_o = (wr_i && addr_i == A_RAW) ? wdata_i : '0;

  always_comb begin
    case (addr_i)
      A_MASK:  rd_mux = mask_q;
      A_RAW:   rd_mux = raw_i;
      A_STAT:  rd_mux = status_i;
      A_POL:   rd_mux = pol_q;
      A_TYPE:  rd_mux = type_q;
      A_FIQ:   rd_mux = fiq_q;
      default: rd_mux = '0;
    endcase
  end

  assign rdata_o = rd_i ? rd_mux : '0;
  assign mask_o  = mask_q;
  assign pol_o   = pol_q;
  assign type_o  = type_q;
  assign fiq_o   = fiq_q;
endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
  import irq_fiq_ctrl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_i,
  input  logic [NSRC-1:0] wdata_i,
  input  logic            rd_i,
  output logic [NSRC-1:0] rdata_o,
  output logic            irq_o,
  output logic            fiq_o
);
  logic [NSRC-1:0] sync, raw, status, evt, latch;
  logic [NSRC-1:0] mask_q, pol_q, type_q, fiq_q, ack;

  irq_fiq_sync #(.W(NSRC), .STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(src_i), .q_o(sync)
  );

  irq_fiq_detect #(.W(NSRC)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync), .pol_i(pol_q),
    .type_i(type_q), .ack_i(ack), .evt_o(evt), .latch_o(latch), .raw_o(raw)
  );

  irq_fiq_regs #(.W(NSRC)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rd_i(rd_i), .rdata_o(rdata_o), .raw_i(raw),
    .status_i(status), .mask_o(mask_q), .pol_o(pol_q), .type_o(type_q),
    .fiq_o(fiq_q), .ack_o(ack)
  );

  assign status = raw & mask_q;
  assign irq_o  = |(status & ~fiq_q);
  assign fiq_o  = |(status & fiq_q);
endmodule

// File: rtl/irq_fiq_ctrl_chk.sv
module irq_fiq_ctrl_chk
  import irq_fiq_ctrl_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [AW-1:0]   addr_i,
  input logic            wr_i,
  input logic [NSRC-1:0] wdata_i,
  input logic            irq_o,
  input logic            fiq_o,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] fiq_q,
  input logic [NSRC-1:0] type_q,
  input logic [NSRC-1:0] status,
  input logic [NSRC-1:0] evt,
  input logic [NSRC-1:0] latch
);
  // R9
  mask_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> (!irq_o && !fiq_o));

  // R10
  fiq_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> ((status & fiq_q) != '0));

  // R10
  irq_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((status & ~fiq_q) != '0));

  // R6
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_RAW) |=> ((latch & $past(wdata_i & ~evt)) == '0));

  // R8
  edge_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt & type_q) != '0) |=> ((latch & $past(evt & type_q)) == $past(evt & type_q)));
endmodule

bind irq_fiq_ctrl irq_fiq_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .fiq_o(fiq_o), .mask_q(mask_q),
  .fiq_q(fiq_q), .type_q(type_q), .status(status), .evt(evt), .latch(latch)
);

// File: tb/sim_irq_fiq_ctrl.sv
module sim_irq_fiq_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] pol;
    logic [31:0] src;
    logic [31:0] mask;
    logic [31:0] route;
    logic [31:0] raw;
    logic [31:0] stat;
    logic        irq;
    logic        fiq;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0,        32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0,        32'h0,        32'h0,        1'b0, 1'b0},
    '{32'hFFFF_FFFF, 32'h0000_00F0, 32'h0000_0030, 32'h0000_0010, 32'h0000_00F0, 32'h0000_0030, 1'b1, 1'b1},
    '{32'h0000_FFFF, 32'h0000_FFFF, 32'hFFFF_0000, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'hFFFF_0000, 1'b0, 1'b1},
    '{32'hAAAA_AAAA, 32'h5555_5555, 32'hFFFF_FFFF, 32'h0,        32'h0,        32'h0,        1'b0, 1'b0},
    '{32'h0,        32'hFFFF_FFFE, 32'h0000_0001, 32'h0,        32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0},
    '{32'h0,        32'hFFFF_FFFE, 32'h0,        32'h0,        32'h0000_0001, 32'h0,        1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  int          errs = 0;
  int          checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_fiq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr), .wr_i(wr),
    .wdata_i(wdata), .rd_i(rd), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errs++; checks++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R2 reset state
    rreg(3'd0, v); chk("R2 mask", v, 32'h0);
    rreg(3'd3, v); chk("R2 pol", v, 32'h0);
    rreg(3'd4, v); chk("R2 type", v, 32'h0);
    rreg(3'd5, v); chk("R2 route", v, 32'h0);
    chk("R2 outputs", {30'h0, irq, fiq}, 32'h0);
    // R4 default active-low level with inputs low
    rreg(3'd1, v); chk("R4 raw default", v, 32'hFFFF_FFFF);
    // R1 unmapped index and strobe gating
    rreg(3'd7, v); chk("R1 unmapped", v, 32'h0);
    #1 chk("R1 no strobe", rdata, 32'h0);

    // table: level polarity, mask, routing
    for (int i = 0; i < 6; i++) begin
      wreg(3'd3, VECS[i].pol);
      wreg(3'd0, VECS[i].mask);
      wreg(3'd5, VECS[i].route);
      src = VECS[i].src;
      tick(2);
      rreg(3'd1, v); chk($sformatf("R4 raw v%0d", i), v, VECS[i].raw);
      rreg(3'd2, v); chk($sformatf("R9 status v%0d", i), v, VECS[i].stat);
      chk($sformatf("R10 outs v%0d", i), {30'h0, irq, fiq}, {30'h0, VECS[i].irq, VECS[i].fiq});
    end

    // R3 two-stage latency
    wreg(3'd3, 32'hFFFF_FFFF);
    wreg(3'd0, 32'h0);
    src = '0;
    tick(3);
    src[5] = 1'b1;
    tick(1);
    rreg(3'd1, v); chk("R3 after one edge", v & 32'h20, 32'h0);
    tick(1);
    rreg(3'd1, v); chk("R3 after two edges", v & 32'h20, 32'h20);

    // edge setup: bits 0,2 rising; bit 1 falling, routed fast
    src = '0;
    tick(4);
    wreg(3'd3, 32'h0000_0105);
    wreg(3'd4, 32'h0000_0007);
    wreg(3'd0, 32'h0000_0107);
    wreg(3'd5, 32'h0000_0002);
    src[1] = 1'b1;
    tick(4);
    rreg(3'd1, v); chk("R5 wrong direction", v & 32'h7, 32'h0);

    src[0] = 1'b1;
    tick(2);
    rreg(3'd1, v); chk("R5 not yet latched", v & 32'h1, 32'h0);
    tick(1);
    rreg(3'd1, v); chk("R5 rising latched", v & 32'h1, 32'h1);
    chk("R10 irq on", {31'h0, irq}, 32'h1);
    src[0] = 1'b0;
    tick(4);
    rreg(3'd1, v); chk("R5 held", v & 32'h1, 32'h1);
    wreg(3'd1, 32'h0);
    rreg(3'd1, v); chk("R6 zero write", v & 32'h1, 32'h1);
    wreg(3'd1, 32'h1);
    rreg(3'd1, v); chk("R6 ack clears", v & 32'h1, 32'h0);
    chk("R6 irq off", {31'h0, irq}, 32'h0);

    src[1] = 1'b0;
    tick(4);
    rreg(3'd1, v); chk("R5 falling latched", v & 32'h2, 32'h2);
    chk("R10 fast route", {30'h0, irq, fiq}, 32'h1);
    wreg(3'd1, 32'h2);
    chk("R6 fiq off", {31'h0, fiq}, 32'h0);

    // R7 level source acknowledge
    src[8] = 1'b1;
    tick(3);
    wreg(3'd1, 32'h100);
    rreg(3'd1, v); chk("R7 level stays", v & 32'h100, 32'h100);

    // R8 edge and acknowledge on the same clock edge
    src[2] = 1'b1;
    tick(4);
    src[2] = 1'b0;
    tick(4);
    rreg(3'd1, v); chk("R8 prior pending", v & 32'h4, 32'h4);
    src[2] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    wreg(3'd1, 32'h4);
    rreg(3'd1, v); chk("R8 edge wins", v & 32'h4, 32'h4);
    wreg(3'd1, 32'h4);
    rreg(3'd1, v); chk("R8 later ack", v & 32'h4, 32'h0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule